// File: doc/BRIEF.md
# Switch Monitor Serial Command Core

This block is the digital heart of an eight-input switch monitor that a host microcontroller controls over a 24-bit SPI link (mode 0). The host sends fixed-length command frames. The upper byte of each frame selects a configuration register and the lower bits carry its new value. Each programmable input can be set to sense a switch closing to battery or a switch closing to ground. The core corrects the raw comparator level with that setting, so a closed switch always reads as 1.

When chip select falls, the core freezes the corrected switch states into its response shift register and clocks them out while the host shifts in its command. An active-low interrupt tells the host that a monitored switch has changed state. The interrupt is released when a frame ends, unless a switch closed while that frame was in progress. The core only holds the register bits for the analog side (wetting current, timers, tri-state control and the channel selection); it does not drive that circuitry.

All SPI pins are brought into the system clock domain through two synchronizer flops and then edge-detected. The raw comparator levels are taken as already synchronous to `clk`. Reset is synchronous and active high.

Top module: `switch_monitor_core`

## Requirements
- R1: A frame is the set of SCLK rising edges seen while chip select is low. MOSI is sampled MSB first on each rising edge. Only a frame of exactly 24 edges is acted on. A frame of any other length leaves every register unchanged.
- R2: Frame bits 23..16 hold the command code and bits 15..0 hold the payload. Code 0x01 loads payload bits 7..0 into the polarity selects for inputs 7..0 and ignores bits 15..8. A select of 1 means the switch closes to battery; a select of 0 means it closes to ground.
- R3: The corrected state of input n is `sw_raw[n] XOR NOT polarity[n]`. A closed switch reads 1 whichever polarity is selected.
- R4: On the falling edge of chip select, the corrected states are captured into the response. The response has inputs 7..0 at bits 7..0 and zero at bits 23..8. It is shifted out MSB first on MISO, advancing on SCLK falling edges. Input changes after the capture do not affect the frame in progress.
- R5: Payload bits 7..0 are loaded by codes 0x02 (wake enable), 0x03 (wetting current enable), 0x04 (wetting timer enable) and 0x05 (tri-state, 1 = tri-stated). Code 0x06 loads payload bits 4..0 into the channel selection. Any other code, including 0x00, changes nothing.
- R6: Reset and code 0x7F both set the same defaults: polarity all 1, wake enable all 1, wetting current all 1, timer all 1, tri-state all 1, and channel selection 00000.
- R7: A valid frame writes its register only when `normal_mode` and `logic_pwr_ok` are both 1. Otherwise the register is unchanged.
- R8: While chip select is high, any change in the corrected state of a wake-enabled input drives `irq_n` low one clock later. This includes a change caused by a new polarity select. Changes on inputs whose wake enable is 0 leave `irq_n` unchanged.
- R9: `irq_n` returns high when chip select rises. The exception is a wake-enabled input that went from 0 to 1 (corrected) while chip select was low: then `irq_n` stays low after the frame. An input that opens during a frame does not hold the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| normal_mode | input | 1 | 1 when the device is in its normal (awake) mode |
| logic_pwr_ok | input | 1 | 1 when the interface logic supply is present |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial command data from the host |
| spi_miso | output | 1 | Serial response data to the host |
| sw_raw | input | 8 | Raw comparator levels of the programmable inputs |
| irq_n | output | 1 | Active-low interrupt to the host |
| cfg_polarity | output | 8 | Polarity selects (1 = switch to battery) |
| cfg_wake_en | output | 8 | Wake / interrupt enables |
| cfg_wet_en | output | 8 | Wetting current enables |
| cfg_timer_en | output | 8 | Wetting timer enables |
| cfg_tristate | output | 8 | Input tri-state controls |
| cfg_chan_sel | output | 5 | Channel selection for the analog path |

## Verification
A pin edge on an SPI input acts three clocks later: two synchronizer flops plus the edge-detect register. A register write shows on the `cfg_*` ports one clock after the rising edge of chip select is detected. An idle switch change reaches `irq_n` on the next clock. The bench holds each SCLK level for four clocks and samples MISO just before raising SCLK. It waits ten clocks after chip select rises before reading the registers or `irq_n`, and a few clocks after any idle input change. Every observation happens on the falling clock edge, well clear of these latencies.

// File: rtl/swm_pkg.sv
package swm_pkg;

    parameter int FRAME_W = 24;
    parameter int CMD_W   = 8;
    parameter int NSW     = 8;
    parameter int CHAN_W  = 5;
    localparam int PAY_W  = FRAME_W - CMD_W;
    localparam int CNT_W  = $clog2(FRAME_W + 2);

    typedef enum logic [CMD_W-1:0] {
        OP_POLARITY = 8'h01,
        OP_WAKE     = 8'h02,
        OP_WETTING  = 8'h03,
        OP_TIMER    = 8'h04,
        OP_TRISTATE = 8'h05,
        OP_CHANNEL  = 8'h06,
        OP_DEFAULTS = 8'h7F
    } opcode_e;

    typedef struct packed {
        logic [CMD_W-1:0] code;
        logic [PAY_W-1:0] payload;
    } frame_t;

    typedef struct packed {
        logic [NSW-1:0]    polarity;
        logic [NSW-1:0]    wake_en;
        logic [NSW-1:0]    wet_en;
        logic [NSW-1:0]    timer_en;
        logic [NSW-1:0]    tristate;
        logic [CHAN_W-1:0] chan_sel;
    } cfg_t;

    function automatic cfg_t cfg_defaults();
        cfg_t c;
        c.polarity = '1;
        c.wake_en  = '1;
        c.wet_en   = '1;
        c.timer_en = '1;
        c.tristate = '1;
        c.chan_sel = '0;
        return c;
    endfunction

    // closed switch reads 1 for either polarity
    function automatic logic [NSW-1:0] correct_state(input logic [NSW-1:0] raw,
                                                     input logic [NSW-1:0] pol);
        return raw ^ ~pol;
    endfunction

endpackage

// File: rtl/swm_spi_shift.sv
module swm_spi_shift
    import swm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sclk,
    input  logic           cs_n,
    input  logic           mosi,
    input  logic [NSW-1:0] status_in,
    output logic           miso,
    output logic           cs_low,
    output logic           cs_rise,
    output logic           frame_ok,
    output frame_t         frame
);

    localparam int ZPAD = FRAME_W - NSW;

    logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
    logic sclk_s, cs_s, mosi_s, sclk_p, cs_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sync <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
            sclk_p    <= 1'b0;
            cs_p      <= 1'b1;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
            sclk_p    <= sclk_s;
            cs_p      <= cs_s;
        end
    end

    assign sclk_s = sclk_sync[SYNC_STAGES-1];
    assign cs_s   = cs_sync[SYNC_STAGES-1];
    assign mosi_s = mosi_sync[SYNC_STAGES-1];

    logic sclk_rise, sclk_fall, cs_fall;
    assign sclk_rise = sclk_s & ~sclk_p;
    assign sclk_fall = ~sclk_s & sclk_p;
    assign cs_fall   = cs_p & ~cs_s;
    assign cs_rise   = ~cs_p & cs_s;
    assign cs_low    = ~cs_s;

    logic [FRAME_W-1:0] rx_sr, tx_sr;
    logic [CNT_W-1:0]   edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr    <= '0;
            tx_sr    <= '0;
            edge_cnt <= '0;
            frame_ok <= 1'b0;
            frame    <= '0;
        end else begin
            frame_ok <= 1'b0;
            if (cs_fall) begin
                tx_sr    <= {{ZPAD{1'b0}}, status_in};
                rx_sr    <= '0;
                edge_cnt <= '0;
            end else if (!cs_s) begin
                if (sclk_rise) begin
                    rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
                    if (edge_cnt != CNT_W'(FRAME_W + 1))
                        edge_cnt <= edge_cnt + 1'b1;
                end
                if (sclk_fall && edge_cnt != '0)
                    tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
            if (cs_rise) begin
                frame_ok <= (edge_cnt == CNT_W'(FRAME_W));
                frame    <= frame_t'(rx_sr);
            end
        end
    end

    assign miso = tx_sr[FRAME_W-1];

    // R1
    frame_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
        frame_ok |-> $past(cs_rise));

    // R4
    tx_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_s && $past(cs_s)) |-> $stable(tx_sr));

endmodule

// File: rtl/swm_cfg_regs.sv
module swm_cfg_regs
    import swm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_ok,
    input  frame_t frame,
    input  logic   wr_allow,
    output cfg_t   cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_defaults();
        end else if (frame_ok && wr_allow) begin
            case (frame.code)
                OP_POLARITY: cfg.polarity <= frame.payload[NSW-1:0];
                OP_WAKE:     cfg.wake_en  <= frame.payload[NSW-1:0];
                OP_WETTING:  cfg.wet_en   <= frame.payload[NSW-1:0];
                OP_TIMER:    cfg.timer_en <= frame.payload[NSW-1:0];
                OP_TRISTATE: cfg.tristate <= frame.payload[NSW-1:0];
                OP_CHANNEL:  cfg.chan_sel <= frame.payload[CHAN_W-1:0];
                OP_DEFAULTS: cfg <= cfg_defaults();
                default: ;
            endcase
        end
    end

    // R7
    cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_ok && wr_allow) |=> $stable(cfg));

endmodule

// File: rtl/swm_irq.sv
module swm_irq
    import swm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NSW-1:0] state,
    input  logic [NSW-1:0] wake_en,
    input  logic           cs_low,
    input  logic           cs_rise,
    output logic           irq_n
);

    logic [NSW-1:0] state_q;
    logic           pend, held;
    logic [NSW-1:0] moved, closed;

    assign moved  = (state ^ state_q) & wake_en;
    assign closed = state & ~state_q & wake_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            pend    <= 1'b0;
            held    <= 1'b0;
        end else begin
            state_q <= state;
            if (cs_rise) begin
                pend <= held | (|closed);
                held <= 1'b0;
            end else if (cs_low) begin
                if (|closed) held <= 1'b1;
            end else if (|moved) begin
                pend <= 1'b1;
            end
        end
    end

    assign irq_n = ~pend;

    // R8
    irq_set_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(!cs_low));

    // R9
    irq_clear_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> $past(cs_rise));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && held) |=> pend);

endmodule

// File: rtl/switch_monitor_core.sv
module switch_monitor_core
    import swm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              normal_mode,
    input  logic              logic_pwr_ok,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [NSW-1:0]    sw_raw,
    output logic              irq_n,
    output logic [NSW-1:0]    cfg_polarity,
    output logic [NSW-1:0]    cfg_wake_en,
    output logic [NSW-1:0]    cfg_wet_en,
    output logic [NSW-1:0]    cfg_timer_en,
    output logic [NSW-1:0]    cfg_tristate,
    output logic [CHAN_W-1:0] cfg_chan_sel
);

    cfg_t           cfg;
    frame_t         frame;
    logic           frame_ok, cs_low, cs_rise;
    logic [NSW-1:0] sw_state;

    assign sw_state = correct_state(sw_raw, cfg.polarity);

    swm_spi_shift #(.SYNC_STAGES(2)) u_spi (
        .clk       (clk),
        .rst       (rst),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .status_in (sw_state),
        .miso      (spi_miso),
        .cs_low    (cs_low),
        .cs_rise   (cs_rise),
        .frame_ok  (frame_ok),
        .frame     (frame)
    );

    swm_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .frame_ok (frame_ok),
        .frame    (frame),
        .wr_allow (normal_mode & logic_pwr_ok),
        .cfg      (cfg)
    );

    swm_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .state   (sw_state),
        .wake_en (cfg.wake_en),
        .cs_low  (cs_low),
        .cs_rise (cs_rise),
        .irq_n   (irq_n)
    );

    assign cfg_polarity = cfg.polarity;
    assign cfg_wake_en  = cfg.wake_en;
    assign cfg_wet_en   = cfg.wet_en;
    assign cfg_timer_en = cfg.timer_en;
    assign cfg_tristate = cfg.tristate;
    assign cfg_chan_sel = cfg.chan_sel;

endmodule

// File: tb/tb_switch_monitor_core.sv
module tb_switch_monitor_core;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    // {polarity, raw}
    localparam logic [15:0] VEC [NV] = '{16'hFF_A5, 16'h00_A5, 16'hF0_3C, 16'h0F_3C};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic normal_mode = 1'b1, logic_pwr_ok = 1'b1;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, irq_n;
    logic [7:0] sw_raw = 8'h00;
    logic [7:0] cfg_polarity, cfg_wake_en, cfg_wet_en, cfg_timer_en, cfg_tristate;
    logic [4:0] cfg_chan_sel;

    int n_checks = 0, n_fail = 0;
    logic [23:0] rsp;

    always #(CLK_PERIOD/2) clk = ~clk;

    switch_monitor_core dut (
        .clk(clk), .rst(rst), .normal_mode(normal_mode), .logic_pwr_ok(logic_pwr_ok),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .sw_raw(sw_raw), .irq_n(irq_n), .cfg_polarity(cfg_polarity), .cfg_wake_en(cfg_wake_en),
        .cfg_wet_en(cfg_wet_en), .cfg_timer_en(cfg_timer_en), .cfg_tristate(cfg_tristate),
        .cfg_chan_sel(cfg_chan_sel)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // chg_at: SCLK edge index at which sw_raw takes chg_val (-1 for none)
    task automatic spi_xfer(input logic [23:0] tx, input int nbits, input int chg_at,
                            input logic [7:0] chg_val, output logic [23:0] rx);
        rx = '0;
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 24) ? tx[23-i] : 1'b0;
            repeat (4) @(negedge clk);
            rx = {rx[22:0], spi_miso};
            spi_sclk = 1'b1;
            if (i == chg_at) sw_raw = chg_val;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic cmd(input logic [23:0] tx);
        logic [23:0] d;
        spi_xfer(tx, 24, -1, 8'h00, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R6 reset defaults
        check(cfg_polarity == 8'hFF, "R6", "reset polarity", cfg_polarity, 8'hFF);
        check(cfg_wake_en == 8'hFF && cfg_wet_en == 8'hFF && cfg_timer_en == 8'hFF,
              "R6", "reset wake/wet/timer", {cfg_wake_en, cfg_wet_en, cfg_timer_en}, 24'hFFFFFF);
        check(cfg_tristate == 8'hFF && cfg_chan_sel == 5'd0, "R6", "reset tristate/chan",
              {cfg_tristate, 3'b0, cfg_chan_sel}, 16'hFF00);
        check(irq_n == 1'b1, "R8", "reset irq_n", irq_n, 1);

        // R2 R3 R4 table: write polarity, then read corrected states
        for (int v = 0; v < NV; v++) begin
            cmd({8'h01, 8'hAB, VEC[v][15:8]});
            check(cfg_polarity == VEC[v][15:8], "R2", "polarity write", cfg_polarity, VEC[v][15:8]);
            sw_raw = VEC[v][7:0];
            spi_xfer(24'h000000, 24, -1, 8'h00, rsp);
            check(rsp == {16'h0, VEC[v][7:0] ^ ~VEC[v][15:8]}, "R3", "corrected response",
                  rsp, {16'h0, VEC[v][7:0] ^ ~VEC[v][15:8]});
        end
        check(cfg_polarity == 8'h0F, "R5", "code 0x00 changes nothing", cfg_polarity, 8'h0F);

        // R5 other registers
        cmd({8'h03, 16'h0055});
        cmd({8'h04, 16'h0033});
        cmd({8'h05, 16'h000F});
        cmd({8'h06, 16'hFFF5});
        cmd({8'h02, 16'h00C3});
        check(cfg_wet_en == 8'h55, "R5", "wetting write", cfg_wet_en, 8'h55);
        check(cfg_timer_en == 8'h33, "R5", "timer write", cfg_timer_en, 8'h33);
        check(cfg_tristate == 8'h0F, "R5", "tristate write", cfg_tristate, 8'h0F);
        check(cfg_chan_sel == 5'h15, "R5", "channel write", cfg_chan_sel, 5'h15);
        check(cfg_wake_en == 8'hC3, "R5", "wake write", cfg_wake_en, 8'hC3);
        cmd({8'h42, 16'h0000});
        check(cfg_wake_en == 8'hC3 && cfg_wet_en == 8'h55, "R5", "unknown code ignored",
              {cfg_wake_en, cfg_wet_en}, 16'hC355);

        // R6 defaults command
        cmd({8'h7F, 16'h0000});
        check({cfg_polarity, cfg_wake_en, cfg_wet_en, cfg_timer_en} == 32'hFFFFFFFF,
              "R6", "defaults cmd regs", {cfg_polarity, cfg_wake_en, cfg_wet_en, cfg_timer_en}, 32'hFFFFFFFF);
        check(cfg_tristate == 8'hFF && cfg_chan_sel == 5'd0, "R6", "defaults cmd tristate/chan",
              {cfg_tristate, 3'b0, cfg_chan_sel}, 16'hFF00);

        // R7 write gating
        normal_mode = 1'b0;
        cmd({8'h01, 16'h0000});
        check(cfg_polarity == 8'hFF, "R7", "write outside normal mode", cfg_polarity, 8'hFF);
        normal_mode = 1'b1; logic_pwr_ok = 1'b0;
        cmd({8'h01, 16'h0000});
        check(cfg_polarity == 8'hFF, "R7", "write without logic supply", cfg_polarity, 8'hFF);
        logic_pwr_ok = 1'b1;

        // R1 wrong frame lengths
        spi_xfer({8'h01, 16'h0000}, 23, -1, 8'h00, rsp);
        check(cfg_polarity == 8'hFF, "R1", "23-edge frame dropped", cfg_polarity, 8'hFF);
        spi_xfer({8'h01, 16'h0000}, 25, -1, 8'h00, rsp);
        check(cfg_polarity == 8'hFF, "R1", "25-edge frame dropped", cfg_polarity, 8'hFF);

        // R4 capture at chip-select fall
        sw_raw = 8'h00;
        spi_xfer(24'h0, 24, 0, 8'hFF, rsp);
        check(rsp == 24'h0, "R4", "change after capture not seen", rsp, 0);
        spi_xfer(24'h0, 24, -1, 8'h00, rsp);
        check(rsp == 24'h0000FF, "R4", "next frame sees change", rsp, 24'hFF);
        sw_raw = 8'h00;
        repeat (3) @(negedge clk);
        cmd(24'h0);
        check(irq_n == 1'b1, "R9", "frame clears irq", irq_n, 1);

        // R8 idle change
        sw_raw = 8'h04;
        repeat (3) @(negedge clk);
        check(irq_n == 1'b0, "R8", "idle change asserts irq", irq_n, 0);
        spi_xfer(24'h0, 24, -1, 8'h00, rsp);
        check(irq_n == 1'b1, "R9", "irq released at frame end", irq_n, 1);
        check(rsp[7:0] == 8'h04, "R4", "status read", rsp, 8'h04);

        // R9 closure during frame holds irq
        spi_xfer(24'h0, 24, 10, 8'h24, rsp);
        check(irq_n == 1'b0, "R9", "closure during frame holds irq", irq_n, 0);
        cmd(24'h0);
        check(irq_n == 1'b1, "R9", "quiet frame clears held irq", irq_n, 1);
        spi_xfer(24'h0, 24, 10, 8'h04, rsp);
        check(irq_n == 1'b1, "R9", "opening during frame does not hold", irq_n, 1);

        // R8 wake-disabled input
        cmd({8'h02, 16'h00FE});
        sw_raw = 8'h05;
        repeat (3) @(negedge clk);
        check(irq_n == 1'b1, "R8", "disabled input no irq", irq_n, 1);
        sw_raw = 8'h07;
        repeat (3) @(negedge clk);
        check(irq_n == 1'b0, "R8", "enabled input irq", irq_n, 0);
        cmd(24'h0);

        // R8 polarity change counts as change
        check(irq_n == 1'b1, "R9", "cleared before polarity test", irq_n, 1);
        cmd({8'h01, 16'h00FD});
        check(irq_n == 1'b0, "R8", "polarity change raises irq", irq_n, 0);

        finish_run();
    end

endmodule